// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel NOR flash. It watches each write strobe, along with the address and data word latched for that write, and recognises the keyed multi-write command protocol. A complete and valid command produces a one-cycle operation pulse with a code, plus the address and data of the write that completed it. The pulse goes to an array engine, which this block does not contain. Apart from one input that says a sector erase is running, the engine is treated as abstract.

Most commands start with a two-write unlock key, then a command byte. Some commands go on to further writes: an address/data pair, a second key and a final erase byte, or a counted burst of buffer words. The decoder also keeps the mode of the device: plain read, identification, unlock shortcut, erase held, query table, buffer loading, buffer fault, or secure region. Whether a command byte is accepted depends on that mode.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, `mode` reads 0 (read) and `op_valid` is low. Mode codes are 0 read, 1 identification, 2 unlock shortcut, 3 erase held, 4 query table, 5 buffer loading, 6 buffer fault, 7 secure region.
- R2: Each accepted command raises `op_valid` for exactly one cycle, in the cycle after the completing write. At the same time it presents `op_addr` and `op_data` of that write. Op codes are 1 program, 2 chip erase, 3 sector erase, 4 buffer word, 5 buffer commit, 6 buffer fault, 7 suspend, 8 resume, 9 reset, 10 identification, 11 query, 12 secure enter, 13 secure exit, 14 shortcut enter. The mode changes only on a write.
- R3: The key writes compare only address bits 11:0 and data bits 7:0. A write that breaks a partly entered sequence drops it silently, and the mode is kept.
- R4: Key (data AA at 555h, then 55 at 2AAh), then A0 at 555h, then any address/data write gives a program pulse.
- R5: Key then 90 at 555h gives an identification pulse and enters identification mode. In that mode every write is ignored except a reset byte or a query entry.
- R6: Key, then 80 at 555h, then the key again, then either 10 at 555h (chip erase) or 30 at any address (sector erase). Erase setup is refused while an erase is held.
- R7: A single F0 write at any address gives a reset pulse. It returns to erase-held mode if an erase is held, and to read mode otherwise.
- R8: Key then 20 at 555h enters shortcut mode. There, A0 then any write programs, and 90 then 00 gives a reset pulse back to read. Other writes, F0 included, do nothing.
- R9: One write of 98 with address bits 11:0 equal to 055h enters query mode, but only from read or identification mode. In query mode only F0 acts.
- R10: B0 suspends only while `eng_sect_erase` is high and nothing is held. 30 resumes only in erase-held mode. While an erase is held, program and identification still work.
- R11: Key, then 25 at a sector address, then a count N (0..BUF_WORDS-1), then N+1 writes. Each of these gives a buffer-word pulse. Then 29 at the same sector gives a commit and returns to the base mode.
- R12: A count above BUF_WORDS-1, a buffer word outside the page of the first word, or a wrong commit write gives a buffer-fault pulse and mode 6. Only key then F0 at 555h leaves mode 6, with a reset pulse. A lone F0 does not.
- R13: Key then 88 at 555h enters the secure region. There, key then 90 at 555h then 00 exits with a secure-exit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Latched word address of the write |
| wr_data | input | DATA_W | Latched data of the write |
| eng_sect_erase | input | 1 | Array engine is running a sector erase |
| op_valid | output | 1 | One-cycle operation pulse |
| op_code | output | 4 | Operation code (see R2) |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | DATA_W | Data of the completing write |
| mode | output | 3 | Current mode (see R1) |

## Verification
The buffer-fault mode is the hardest state to reach and to leave. It needs a complete key, a buffer start and then one of three distinct violations: an oversized count, a word that jumps to another page, or a bad commit. The stimulus drives each violation in its own run. It then shows that a lone F0 leaves the decoder stuck in mode 6, and that only the three-write abort key brings it back. The erase-held state is reached by raising the engine's erase flag around a B0 write. The bench then checks that program and identification still work while the erase is held, and that a reset from identification mode lands back in erase-held mode.

// File: rtl/nor_cmd_pkg.sv
// Package: shared types for the flash command decoder.
// Assumes: 3-bit mode and 4-bit op codes are decoded by the array engine.
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        MD_READ       = 3'd0,
        MD_AUTOSEL    = 3'd1,
        MD_BYPASS     = 3'd2,
        MD_ESUSP      = 3'd3,
        MD_CFI        = 3'd4,
        MD_WBUF       = 3'd5,
        MD_WBUF_FAULT = 3'd6,
        MD_SECURE     = 3'd7
    } mode_t;

    typedef enum logic [3:0] {
        OP_NONE         = 4'd0,
        OP_PROGRAM      = 4'd1,
        OP_CHIP_ERASE   = 4'd2,
        OP_SECT_ERASE   = 4'd3,
        OP_BUF_WORD     = 4'd4,
        OP_BUF_COMMIT   = 4'd5,
        OP_BUF_FAULT    = 4'd6,
        OP_SUSPEND      = 4'd7,
        OP_RESUME       = 4'd8,
        OP_RESET        = 4'd9,
        OP_AUTOSEL      = 4'd10,
        OP_CFI          = 4'd11,
        OP_SEC_ENTER    = 4'd12,
        OP_SEC_EXIT     = 4'd13,
        OP_BYPASS_ENTER = 4'd14
    } op_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ER1, ST_ER2, ST_ER3,
        ST_WCNT, ST_WDATA, ST_WCOMMIT, ST_BP_PROG, ST_BP_EXIT, ST_SEC_EXIT
    } step_t;

    localparam int KEY_W = 12;

endpackage

// File: rtl/nor_key_match.sv
// Module: nor_key_match
// Compares one write against the fixed key and command patterns.
// Assumes: only the low 12 address bits and low 8 data bits are relevant.
module nor_key_match
    import nor_cmd_pkg::*;
(
    input  logic [KEY_W-1:0] addr_key,
    input  logic [7:0]       code,
    output logic             key_first,
    output logic             key_second,
    output logic             at_cmd_addr,
    output logic             cfi_hit
);

    // Purpose: decode the partial address/data compares
    always_comb begin
        at_cmd_addr = (addr_key == 12'h555);
        key_first   = at_cmd_addr && (code == 8'hAA);
        key_second  = (addr_key == 12'h2AA) && (code == 8'h55);
        cfi_hit     = (addr_key == 12'h055) && (code == 8'h98);
    end

endmodule

// File: rtl/nor_wbuf_track.sv
// Module: nor_wbuf_track
// Holds the remaining word count, the page of the first buffer word and
// the sector given with the buffer start.
// Assumes: the top strobes start, cnt_ld and word only on accepted writes.
module nor_wbuf_track #(
    parameter int ADDR_W   = 22,
    parameter int PAGE_LSB = 4,
    parameter int SECT_LSB = 15,
    parameter int CNT_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       cnt_ld,
    input  logic [CNT_W-1:0]           cnt_val,
    input  logic                       word,
    input  logic [ADDR_W-1:PAGE_LSB]   page_addr,
    output logic                       last,
    output logic                       page_ok,
    output logic                       sect_ok
);

    localparam int PG_W = ADDR_W - PAGE_LSB;
    localparam int SC_W = ADDR_W - SECT_LSB;

    logic [CNT_W-1:0] remain_q;
    logic             first_q;
    logic [PG_W-1:0]  page_q;
    logic [SC_W-1:0]  sect_q;
    logic [SC_W-1:0]  sect_in;

    assign sect_in = page_addr[ADDR_W-1:SECT_LSB];

    // Purpose: track count, page anchor and sector of the open buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            first_q  <= 1'b0;
            page_q   <= '0;
            sect_q   <= '0;
        end else begin
            if (start) begin
                sect_q  <= sect_in;
                first_q <= 1'b1;
            end
            if (cnt_ld) remain_q <= cnt_val;
            if (word) begin
                if (first_q) page_q <= page_addr;
                first_q  <= 1'b0;
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    // Purpose: flags used by the sequence FSM
    always_comb begin
        last    = (remain_q == '0);
        page_ok = first_q || (page_addr == page_q);
        sect_ok = (sect_in == sect_q);
    end

    AST_WB_WORD_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        word |-> page_ok); // R12

endmodule

// File: rtl/nor_cmd_decoder.sv
// Module: nor_cmd_decoder (top)
// Decodes keyed multi-write flash commands into one-cycle operation pulses
// and keeps the device mode.
// Assumes: wr_stb is high for one cycle per write with address and data
// stable; eng_sect_erase is high while the engine runs a sector erase.
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int BUF_WORDS = 16,
    parameter int SECT_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              eng_sect_erase,
    output logic              op_valid,
    output logic [3:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [2:0]        mode
);

    localparam int CNT_W    = $clog2(BUF_WORDS);
    localparam int PAGE_LSB = $clog2(BUF_WORDS);
    localparam logic [DATA_W-1:0] MAX_CNT = DATA_W'(BUF_WORDS - 1);

    step_t step_q, step_d;
    mode_t mode_q, mode_d, base_mode;
    op_t   op_q, op_d;
    logic  susp_q, susp_d;
    logic  op_valid_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] op_data_q;

    logic       key_first, key_second, at_cmd_addr, cfi_hit;
    logic [7:0] code;
    logic       wb_start, wb_cnt_ld, wb_word, wb_last, wb_page_ok, wb_sect_ok;

    assign code = wr_data[7:0];

    nor_key_match i_match (
        .addr_key    (wr_addr[KEY_W-1:0]),
        .code        (code),
        .key_first   (key_first),
        .key_second  (key_second),
        .at_cmd_addr (at_cmd_addr),
        .cfi_hit     (cfi_hit)
    );

    nor_wbuf_track #(
        .ADDR_W   (ADDR_W),
        .PAGE_LSB (PAGE_LSB),
        .SECT_LSB (SECT_LSB),
        .CNT_W    (CNT_W)
    ) i_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wb_start),
        .cnt_ld    (wb_cnt_ld),
        .cnt_val   (wr_data[CNT_W-1:0]),
        .word      (wb_word),
        .page_addr (wr_addr[ADDR_W-1:PAGE_LSB]),
        .last      (wb_last),
        .page_ok   (wb_page_ok),
        .sect_ok   (wb_sect_ok)
    );

    // Purpose: next step, mode and operation for the current write
    always_comb begin
        step_d    = step_q;
        mode_d    = mode_q;
        susp_d    = susp_q;
        op_d      = OP_NONE;
        wb_start  = 1'b0;
        wb_cnt_ld = 1'b0;
        wb_word   = 1'b0;
        base_mode = susp_q ? MD_ESUSP : MD_READ;
        if (wr_stb) begin
            step_d = ST_IDLE;
            case (step_q)
                ST_IDLE: begin
                    case (mode_q)
                        MD_AUTOSEL: begin
                            if (code == 8'hF0) begin
                                op_d = OP_RESET; mode_d = base_mode;
                            end else if (cfi_hit) begin
                                op_d = OP_CFI; mode_d = MD_CFI;
                            end
                        end
                        MD_CFI: begin
                            if (code == 8'hF0) begin
                                op_d = OP_RESET; mode_d = base_mode;
                            end
                        end
                        MD_BYPASS: begin
                            if (code == 8'hA0)      step_d = ST_BP_PROG;
                            else if (code == 8'h90) step_d = ST_BP_EXIT;
                        end
                        MD_WBUF_FAULT: begin
                            if (key_first) step_d = ST_KEY1;
                        end
                        default: begin
                            if (key_first) begin
                                step_d = ST_KEY1;
                            end else if (code == 8'hF0) begin
                                op_d = OP_RESET; mode_d = base_mode;
                            end else if (cfi_hit && mode_q == MD_READ) begin
                                op_d = OP_CFI; mode_d = MD_CFI;
                            end else if (code == 8'hB0 && eng_sect_erase && !susp_q) begin
                                op_d = OP_SUSPEND; susp_d = 1'b1; mode_d = MD_ESUSP;
                            end else if (code == 8'h30 && mode_q == MD_ESUSP) begin
                                op_d = OP_RESUME; susp_d = 1'b0; mode_d = MD_READ;
                            end
                        end
                    endcase
                end
                ST_KEY1: if (key_second) step_d = ST_KEY2;
                ST_KEY2: begin
                    if (mode_q == MD_WBUF_FAULT) begin
                        if (code == 8'hF0 && at_cmd_addr) begin
                            op_d = OP_RESET; mode_d = base_mode;
                        end
                    end else if (code == 8'h25) begin
                        wb_start = 1'b1; step_d = ST_WCNT; mode_d = MD_WBUF;
                    end else if (at_cmd_addr) begin
                        case (code)
                            8'h90: begin
                                if (mode_q == MD_SECURE) step_d = ST_SEC_EXIT;
                                else begin
                                    op_d = OP_AUTOSEL; mode_d = MD_AUTOSEL;
                                end
                            end
                            8'hA0: step_d = ST_PROG;
                            8'h88: begin
                                op_d = OP_SEC_ENTER; mode_d = MD_SECURE;
                            end
                            8'h20: if (mode_q == MD_READ) begin
                                op_d = OP_BYPASS_ENTER; mode_d = MD_BYPASS;
                            end
                            8'h80: if (!susp_q) step_d = ST_ER1;
                            default: ;
                        endcase
                    end
                end
                ST_PROG, ST_BP_PROG: op_d = OP_PROGRAM;
                ST_ER1: if (key_first)  step_d = ST_ER2;
                ST_ER2: if (key_second) step_d = ST_ER3;
                ST_ER3: begin
                    if (code == 8'h10 && at_cmd_addr) op_d = OP_CHIP_ERASE;
                    else if (code == 8'h30)           op_d = OP_SECT_ERASE;
                end
                ST_WCNT: begin
                    if (wr_data > MAX_CNT) begin
                        op_d = OP_BUF_FAULT; mode_d = MD_WBUF_FAULT;
                    end else begin
                        wb_cnt_ld = 1'b1; step_d = ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (!wb_page_ok) begin
                        op_d = OP_BUF_FAULT; mode_d = MD_WBUF_FAULT;
                    end else begin
                        op_d = OP_BUF_WORD; wb_word = 1'b1;
                        step_d = wb_last ? ST_WCOMMIT : ST_WDATA;
                    end
                end
                ST_WCOMMIT: begin
                    if (code == 8'h29 && wb_sect_ok) begin
                        op_d = OP_BUF_COMMIT; mode_d = base_mode;
                    end else begin
                        op_d = OP_BUF_FAULT; mode_d = MD_WBUF_FAULT;
                    end
                end
                ST_BP_EXIT: if (code == 8'h00) begin
                    op_d = OP_RESET; mode_d = base_mode;
                end
                ST_SEC_EXIT: if (code == 8'h00) begin
                    op_d = OP_SEC_EXIT; mode_d = base_mode;
                end
                default: ;
            endcase
        end
    end

    // Purpose: state and registered operation outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q     <= ST_IDLE;
            mode_q     <= MD_READ;
            susp_q     <= 1'b0;
            op_q       <= OP_NONE;
            op_valid_q <= 1'b0;
            op_addr_q  <= '0;
            op_data_q  <= '0;
        end else begin
            step_q     <= step_d;
            mode_q     <= mode_d;
            susp_q     <= susp_d;
            op_q       <= op_d;
            op_valid_q <= (op_d != OP_NONE);
            if (wr_stb) begin
                op_addr_q <= wr_addr;
                op_data_q <= wr_data;
            end
        end
    end

    assign op_valid = op_valid_q;
    assign op_code  = op_q;
    assign op_addr  = op_addr_q;
    assign op_data  = op_data_q;
    assign mode     = mode_q;

    AST_OP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_q |-> $past(wr_stb)); // R2
    AST_MODE_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(mode_q)); // R2
    AST_SUSPEND_NEEDS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_q && op_q == OP_SUSPEND) |-> $past(eng_sect_erase)); // R10
    AST_RESUME_FROM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_q && op_q == OP_RESUME) |-> ($past(mode_q) == MD_ESUSP)); // R10
    AST_CFI_SOURCE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_q && op_q == OP_CFI) |->
        ($past(mode_q) == MD_READ || $past(mode_q) == MD_AUTOSEL)); // R9

endmodule

// File: tb/test_nor_cmd_decoder.sv
`timescale 1ns/1ps
module test_nor_cmd_decoder;
    import nor_cmd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [21:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        eng_sect_erase = 1'b0;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [21:0] op_addr;
    logic [15:0] op_data;
    logic [2:0]  mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nor_cmd_decoder i_nor_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .eng_sect_erase(eng_sect_erase),
        .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
        .op_data(op_data), .mode(mode)
    );

    // {req, addr, data, valid, op, mode}
    localparam int NV = 53;
    localparam logic [53:0] TBL [NV] = '{
        {8'd4,  22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_READ},    // R4
        {8'd4,  22'h0002AA, 16'h0055, 1'b0, OP_NONE,         MD_READ},
        {8'd4,  22'h000555, 16'h00A0, 1'b0, OP_NONE,         MD_READ},
        {8'd4,  22'h001234, 16'hBEEF, 1'b1, OP_PROGRAM,      MD_READ},
        {8'd3,  22'h3F1555, 16'h12AA, 1'b0, OP_NONE,         MD_READ},    // R3 high bits ignored
        {8'd3,  22'h02A2AA, 16'hFF55, 1'b0, OP_NONE,         MD_READ},
        {8'd5,  22'h000555, 16'h0090, 1'b1, OP_AUTOSEL,      MD_AUTOSEL}, // R5
        {8'd5,  22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_AUTOSEL},
        {8'd7,  22'h000000, 16'h00F0, 1'b1, OP_RESET,        MD_READ},    // R7
        {8'd6,  22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_READ},    // R6 chip erase
        {8'd6,  22'h0002AA, 16'h0055, 1'b0, OP_NONE,         MD_READ},
        {8'd6,  22'h000555, 16'h0080, 1'b0, OP_NONE,         MD_READ},
        {8'd6,  22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_READ},
        {8'd6,  22'h0002AA, 16'h0055, 1'b0, OP_NONE,         MD_READ},
        {8'd6,  22'h000555, 16'h0010, 1'b1, OP_CHIP_ERASE,   MD_READ},
        {8'd6,  22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_READ},    // R6 sector erase
        {8'd6,  22'h0002AA, 16'h0055, 1'b0, OP_NONE,         MD_READ},
        {8'd6,  22'h000555, 16'h0080, 1'b0, OP_NONE,         MD_READ},
        {8'd6,  22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_READ},
        {8'd6,  22'h0002AA, 16'h0055, 1'b0, OP_NONE,         MD_READ},
        {8'd6,  22'h0A8000, 16'h0030, 1'b1, OP_SECT_ERASE,   MD_READ},
        {8'd3,  22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_READ},    // R3 broken key
        {8'd3,  22'h0002AA, 16'h00AB, 1'b0, OP_NONE,         MD_READ},
        {8'd3,  22'h000555, 16'h00A0, 1'b0, OP_NONE,         MD_READ},
        {8'd3,  22'h001234, 16'h5678, 1'b0, OP_NONE,         MD_READ},
        {8'd8,  22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_READ},    // R8
        {8'd8,  22'h0002AA, 16'h0055, 1'b0, OP_NONE,         MD_READ},
        {8'd8,  22'h000555, 16'h0020, 1'b1, OP_BYPASS_ENTER, MD_BYPASS},
        {8'd8,  22'h000000, 16'h00A0, 1'b0, OP_NONE,         MD_BYPASS},
        {8'd8,  22'h002000, 16'h1111, 1'b1, OP_PROGRAM,      MD_BYPASS},
        {8'd8,  22'h000000, 16'h00F0, 1'b0, OP_NONE,         MD_BYPASS},
        {8'd9,  22'h000055, 16'h0098, 1'b0, OP_NONE,         MD_BYPASS},  // R9 no query from shortcut
        {8'd8,  22'h000000, 16'h0090, 1'b0, OP_NONE,         MD_BYPASS},
        {8'd8,  22'h000000, 16'h0000, 1'b1, OP_RESET,        MD_READ},
        {8'd9,  22'h000055, 16'h0098, 1'b1, OP_CFI,          MD_CFI},     // R9
        {8'd9,  22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_CFI},
        {8'd9,  22'h000000, 16'h00F0, 1'b1, OP_RESET,        MD_READ},
        {8'd13, 22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_READ},    // R13
        {8'd13, 22'h0002AA, 16'h0055, 1'b0, OP_NONE,         MD_READ},
        {8'd13, 22'h000555, 16'h0088, 1'b1, OP_SEC_ENTER,    MD_SECURE},
        {8'd13, 22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_SECURE},
        {8'd13, 22'h0002AA, 16'h0055, 1'b0, OP_NONE,         MD_SECURE},
        {8'd13, 22'h000555, 16'h0090, 1'b0, OP_NONE,         MD_SECURE},
        {8'd13, 22'h000000, 16'h0000, 1'b1, OP_SEC_EXIT,     MD_READ},
        {8'd11, 22'h000555, 16'h00AA, 1'b0, OP_NONE,         MD_READ},    // R11
        {8'd11, 22'h0002AA, 16'h0055, 1'b0, OP_NONE,         MD_READ},
        {8'd11, 22'h0A8000, 16'h0025, 1'b0, OP_NONE,         MD_WBUF},
        {8'd11, 22'h0A8000, 16'h0003, 1'b0, OP_NONE,         MD_WBUF},
        {8'd11, 22'h0A8010, 16'h0001, 1'b1, OP_BUF_WORD,     MD_WBUF},
        {8'd11, 22'h0A8011, 16'h0002, 1'b1, OP_BUF_WORD,     MD_WBUF},
        {8'd11, 22'h0A8012, 16'h0003, 1'b1, OP_BUF_WORD,     MD_WBUF},
        {8'd11, 22'h0A8013, 16'h0004, 1'b1, OP_BUF_WORD,     MD_WBUF},
        {8'd11, 22'h0A8000, 16'h0029, 1'b1, OP_BUF_COMMIT,   MD_READ}
    };

    task automatic chk(input int req, input logic v, input logic [3:0] op,
                       input logic [2:0] md, input logic [21:0] a, input logic [15:0] d);
        logic bad;
        n_chk++;
        bad = (op_valid !== v) || (mode !== md) ||
              (v && ((op_code !== op) || (op_addr !== a) || (op_data !== d)));
        if (bad) begin
            n_fail++;
            $display("FAIL R%0d: got valid=%0b op=%0d mode=%0d addr=%h data=%h, expected valid=%0b op=%0d mode=%0d addr=%h data=%h",
                     req, op_valid, op_code, mode, op_addr, op_data, v, op, md, a, d);
        end
    endtask

    // Drive one write at a falling edge; outputs are sampled one cycle later
    task automatic wr(input logic [21:0] a, input logic [15:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic key();
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0055);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(1, 1'b0, OP_NONE, MD_READ, '0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, 1'b0, OP_NONE, MD_READ, '0, '0);

        for (int i = 0; i < NV; i++) begin
            wr(TBL[i][45:24], TBL[i][23:8]);
            chk(int'(TBL[i][53:46]), TBL[i][7], TBL[i][6:3], TBL[i][2:0],
                TBL[i][45:24], TBL[i][23:8]);
        end
        // R2 pulse lasts one cycle
        @(negedge clk);
        chk(2, 1'b0, OP_NONE, MD_READ, '0, '0);

        // R12 count too large, lone F0 ignored, abort key recovers
        key(); wr(22'h0A8000, 16'h0025);
        wr(22'h0A8000, 16'h0010);
        chk(12, 1'b1, OP_BUF_FAULT, MD_WBUF_FAULT, 22'h0A8000, 16'h0010);
        wr(22'h0, 16'h00F0);
        chk(12, 1'b0, OP_NONE, MD_WBUF_FAULT, '0, '0);
        key(); wr(22'h555, 16'h00F0);
        chk(12, 1'b1, OP_RESET, MD_READ, 22'h555, 16'h00F0);

        // R12 word leaves the page of the first word
        key(); wr(22'h0A8000, 16'h0025); wr(22'h0A8000, 16'h0001);
        wr(22'h0A8010, 16'h0007);
        chk(12, 1'b1, OP_BUF_WORD, MD_WBUF, 22'h0A8010, 16'h0007);
        wr(22'h0A8020, 16'h0008);
        chk(12, 1'b1, OP_BUF_FAULT, MD_WBUF_FAULT, 22'h0A8020, 16'h0008);
        key(); wr(22'h555, 16'h00F0);
        chk(12, 1'b1, OP_RESET, MD_READ, 22'h555, 16'h00F0);

        // R12 wrong commit sector
        key(); wr(22'h0A8000, 16'h0025); wr(22'h0A8000, 16'h0000);
        wr(22'h0A8005, 16'h0009);
        wr(22'h0B0000, 16'h0029);
        chk(12, 1'b1, OP_BUF_FAULT, MD_WBUF_FAULT, 22'h0B0000, 16'h0029);
        key(); wr(22'h555, 16'h00F0);

        // R10 suspend refused without an erase running
        wr(22'h0, 16'h00B0);
        chk(10, 1'b0, OP_NONE, MD_READ, '0, '0);
        eng_sect_erase = 1'b1;
        wr(22'h0, 16'h00B0);
        chk(10, 1'b1, OP_SUSPEND, MD_ESUSP, 22'h0, 16'h00B0);
        wr(22'h0, 16'h00B0);
        chk(10, 1'b0, OP_NONE, MD_ESUSP, '0, '0);
        key(); wr(22'h555, 16'h00A0); wr(22'h004000, 16'h2222);
        chk(10, 1'b1, OP_PROGRAM, MD_ESUSP, 22'h004000, 16'h2222);
        key(); wr(22'h555, 16'h0080);
        chk(6, 1'b0, OP_NONE, MD_ESUSP, '0, '0); // R6 erase refused while held
        key(); wr(22'h555, 16'h0090);
        chk(10, 1'b1, OP_AUTOSEL, MD_AUTOSEL, 22'h555, 16'h0090);
        wr(22'h0, 16'h00F0);
        chk(7, 1'b1, OP_RESET, MD_ESUSP, 22'h0, 16'h00F0); // R7 back to held
        eng_sect_erase = 1'b0;
        wr(22'h0, 16'h0030);
        chk(10, 1'b1, OP_RESUME, MD_READ, 22'h0, 16'h0030);
        wr(22'h0, 16'h0030);
        chk(10, 1'b0, OP_NONE, MD_READ, '0, '0);

        // R5 query reachable from identification mode
        key(); wr(22'h555, 16'h0090);
        wr(22'h055, 16'h0098);
        chk(5, 1'b1, OP_CFI, MD_CFI, 22'h055, 16'h0098);
        wr(22'h0, 16'h00F0);

        // R1 reset mid-sequence clears state
        key(); wr(22'h555, 16'h0020);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk(1, 1'b0, OP_NONE, MD_READ, '0, '0);

        finish_run();
    end

endmodule